// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Sequencer

This block turns host read and write requests into the strobe sequence an asynchronous, address-multiplexed DRAM expects. It drives active-low row strobe, column strobe, write enable and output enable, and a shared address bus that first carries the row and then the column. It also drives the write data with its enable and captures read data from the device. All pin timing is counted in clock cycles set by parameters.

A request to the row already open keeps the row strobe low and pulses only the column strobe with the new column. A request to another row raises the row strobe for a precharge interval and then runs a full row-then-column cycle. An open row that sees no request for a set number of cycles is closed, so the row strobe never stays low indefinitely. For each read, the host chooses whether output enable leads the column strobe or follows it by one cycle.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset ras_n, cas_n, we_n and oe_n are 1, dq_oe is 0, done is 0 and req_ready is 1.
- R2: From a closed row, ras_n falls with the row field req_addr[17:9] on mem_addr. After T_RCD cycles, the column field req_addr[8:0] is placed on mem_addr for one cycle with cas_n high. cas_n then stays low for T_CAS cycles with mem_addr held steady, so that cas_n falls T_RCD+1 cycles after ras_n.
- R3: A request whose row equals the open row produces one cas_n pulse carrying the new column, and ras_n does not toggle.
- R4: A request to a different row raises ras_n for exactly T_RP cycles before ras_n falls again with the new row.
- R5: cas_n is never low while ras_n is high. Between two column pulses in one row, cas_n stays high for at least T_CP+2 cycles: T_CP recovery, at least one cycle waiting for the request, and one setup cycle.
- R6: For a write (req_write=1), we_n is low from the setup cycle before cas_n falls to the end of the cas_n low period. dq_oe is 1 and dq_out carries the write data over the same span, and oe_n stays 1.
- R7: For a read with req_oe_late=0, oe_n is already low in the cycle before cas_n falls.
- R8: For a read with req_oe_late=1, oe_n is high in the first cas_n-low cycle and low in the later ones.
- R9: Read data is sampled from dq_in in the last cas_n-low cycle. done is a one-cycle pulse in the first cycle cas_n is high again, and rdata is valid from that cycle on.
- R10: With no request pending, ras_n stays low for exactly T_CP+T_IDLE cycles after cas_n rises, then goes high.
- R11: req_ready is 1 only while no access is in progress. It is 0 in the cycle after a request is accepted, and requests are accepted only when req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_oe_late | input | 1 | Read only: 1 = output enable after column strobe |
| req_addr | input | 18 | Row in [17:9], column in [8:0] |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this edge when valid |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 9 | Multiplexed row/column address |
| dq_out | output | 8 | Data driven toward the device |
| dq_oe | output | 1 | Enable for dq_out |
| dq_in | input | 8 | Data returned by the device |

## Verification
The bench runs five patterns against a behavioural device model. A write from a closed row shows the row and column multiplexing and the strobe spacing. Back-to-back writes and reads in one row show that page hits leave the row strobe untouched. Alternating rows, including the highest row and column, show that each change of row pays exactly one precharge. Early and late reads are returned from a model that supplies valid data only after output enable and an access delay, so reads taken at the wrong moment come back as wrong data. A final idle stretch shows that the row closes after the set timeout and that the next access starts a full row cycle.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DW     = 8,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 3,
  parameter int T_CP   = 2,
  parameter int T_IDLE = 20,
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_oe_late,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   req_ready,
  output logic                   done,
  output logic [DW-1:0]          rdata,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          dq_out,
  output logic                   dq_oe,
  input  logic [DW-1:0]          dq_in
);
  localparam int CW = $clog2(T_IDLE + T_RP + T_RCD + T_CAS + T_CP + 2);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ROW, S_COLS, S_CAS, S_CHI, S_OPEN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_wr, cur_late, pend;
  logic [DW-1:0]    wdat;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             hit, in_col, row_phase;

  assign req_row   = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign hit       = (req_row == open_row);
  assign req_ready = (st == S_IDLE) || (st == S_OPEN);
  assign in_col    = (st == S_COLS) || (st == S_CAS);
  assign row_phase = (st == S_IDLE) || (st == S_PRE) || (st == S_ROW);

  assign ras_n    = (st == S_IDLE) || (st == S_PRE);
  assign cas_n    = (st != S_CAS);
  assign we_n     = !(in_col && cur_wr);
  assign dq_oe    = in_col && cur_wr;
  assign dq_out   = wdat;
  assign oe_n     = !(in_col && !cur_wr &&
                      (!cur_late || (st == S_CAS && cnt != CW'(T_CAS - 1))));
  assign mem_addr = row_phase ? AW'(open_row) : AW'(cur_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      open_row <= '0;
      cur_col  <= '0;
      cur_wr   <= 1'b0;
      cur_late <= 1'b0;
      pend     <= 1'b0;
      wdat     <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (req_valid && req_ready) begin
        open_row <= req_row;
        cur_col  <= req_col;
        cur_wr   <= req_write;
        cur_late <= req_oe_late;
        wdat     <= req_wdata;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          st  <= S_ROW;
          cnt <= CW'(T_RCD - 1);
        end
        S_OPEN: begin
          if (req_valid && hit) begin
            st <= S_COLS;
          end else if (req_valid || cnt == '0) begin
            st   <= S_PRE;
            cnt  <= CW'(T_RP - 1);
            pend <= req_valid;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            st   <= pend ? S_ROW : S_IDLE;
            cnt  <= CW'(T_RCD - 1);
            pend <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ROW: begin
          if (cnt == '0) st <= S_COLS;
          else           cnt <= cnt - 1'b1;
        end
        S_COLS: begin
          st  <= S_CAS;
          cnt <= CW'(T_CAS - 1);
        end
        S_CAS: begin
          if (cnt == '0) begin
            st   <= S_CHI;
            cnt  <= CW'(T_CP - 1);
            done <= 1'b1;
            if (!cur_wr) rdata <= dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CHI: begin
          if (cnt == '0) begin
            st  <= S_OPEN;
            cnt <= CW'(T_IDLE - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] ras_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ras_hi_cnt <= CW'(T_RP);
    else if (!ras_n)                           ras_hi_cnt <= '0;
    else if (ras_hi_cnt < CW'(T_RP))           ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  a_r4_precharge_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ras_hi_cnt >= CW'(T_RP));

  a_r5_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r6_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(we_n) == we_n);

  a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |-> (dq_oe && oe_n));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(mem_addr));

  a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cas_n) && !ras_n));

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cas_n);
endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 3, T_CP = 2, T_IDLE = 20;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_oe_late = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0] rdata, dq_out, dq_in;
  logic [8:0] mem_addr;

  fpm_dram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_oe_late(req_oe_late), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  logic [7:0] mem [logic [17:0]];
  logic [8:0] row_lat = '0, col_lat = '0;
  logic [7:0] rd_val = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b1;
  logic we_pre = 1'b1, oe_pre = 1'b1, oe_fall = 1'b1, oe_c1 = 1'b1, wr_oe = 1'b0;
  int ras_falls = 0, cas_falls = 0, hi_run = 0, last_hi = 0, hr = 0;
  int last_chi = 0, last_tail = 0, cas_cnt = 0, oe_cnt = 0, last_lo = 0;
  int r5_err = 0, done_err = 0;

  assign dq_in = (cas_cnt >= 2 && oe_cnt >= 2) ? rd_val : ~rd_val;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cas_n && ras_n) r5_err++;
      if (!ras_n && p_ras) begin
        ras_falls++; row_lat = mem_addr; last_hi = hi_run; hr = 0;
      end
      if (ras_n && !p_ras) last_tail = hr;
      if (!cas_n && p_cas) begin
        cas_falls++; col_lat = mem_addr; we_pre = p_we; oe_pre = p_oe;
        oe_fall = oe_n; last_chi = hr; wr_oe = dq_oe;
        if (!we_n) mem[{row_lat, col_lat}] = dq_out;
        rd_val = mem.exists({row_lat, col_lat}) ? mem[{row_lat, col_lat}] : 8'h00;
      end
      if (!cas_n && cas_cnt == 1) oe_c1 = oe_n;
      if (cas_n && !p_cas) begin
        last_lo = cas_cnt; hr = 0;
        if (!done) done_err++;
      end else if (done) done_err++;
      hi_run  = ras_n ? hi_run + 1 : 0;
      cas_cnt = !cas_n ? cas_cnt + 1 : 0;
      oe_cnt  = !oe_n ? oe_cnt + 1 : 0;
      if (!ras_n && cas_n) hr++;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = oe_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic ready_after;

  task automatic access(input logic wr, input logic late, input logic [8:0] row,
                        input logic [8:0] col, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_oe_late = late;
    req_addr = {row, col}; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ready_after = req_ready;
    while (!done) @(negedge clk);
    #1 q = rdata;
  endtask

  task automatic t_reset;
    chk("R1 ras_n", ras_n, 1); chk("R1 cas_n", cas_n, 1);
    chk("R1 we_n", we_n, 1);   chk("R1 oe_n", oe_n, 1);
    chk("R1 dq_oe", dq_oe, 0); chk("R1 done", done, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_closed_write;
    logic [7:0] q;
    int rf = ras_falls;
    access(1, 0, 9'd5, 9'h00A, 8'h3C, q);
    chk("R2 one row open", ras_falls, rf + 1);
    chk("R2 row on bus", row_lat, 9'd5);
    chk("R2 col on bus", col_lat, 9'h00A);
    chk("R2 ras-to-cas", last_chi, T_RCD + 1);
    chk("R2 cas width", last_lo, T_CAS);
    chk("R6 we before cas", we_pre, 0);
    chk("R6 data driven", wr_oe, 1);
    chk("R11 busy after accept", ready_after, 0);
  endtask

  task automatic t_hit_writes;
    logic [7:0] q;
    int rf = ras_falls, cf = cas_falls;
    access(1, 0, 9'd5, 9'h00B, 8'h5A, q);
    access(1, 0, 9'd5, 9'h1FF, 8'hC3, q);
    chk("R3 no ras toggle", ras_falls, rf);
    chk("R3 two cas pulses", cas_falls, cf + 2);
    chk("R3 top column", col_lat, 9'h1FF);
    chk("R5 cas recovery", last_chi >= T_CP + 2, 1);
  endtask

  task automatic t_early_read;
    logic [7:0] q;
    int rf = ras_falls;
    access(0, 0, 9'd5, 9'h00A, 8'h00, q);
    chk("R9 early read data", q, 8'h3C);
    chk("R7 oe before cas", oe_pre, 0);
    chk("R3 read hit keeps row", ras_falls, rf);
  endtask

  task automatic t_late_read;
    logic [7:0] q;
    access(0, 1, 9'd5, 9'h00B, 8'h00, q);
    chk("R9 late read data", q, 8'h5A);
    chk("R8 oe high at cas fall", oe_fall, 1);
    chk("R8 oe low next cycle", oe_c1, 0);
    chk("R8 oe high before cas", oe_pre, 1);
  endtask

  task automatic t_miss;
    logic [7:0] q;
    int rf = ras_falls;
    access(1, 0, 9'h1FF, 9'h000, 8'h77, q);
    chk("R4 precharge width", last_hi, T_RP);
    chk("R4 new row", row_lat, 9'h1FF);
    chk("R4 one reopen", ras_falls, rf + 1);
    access(0, 1, 9'h1FF, 9'h000, 8'h00, q);
    chk("R9 read new row", q, 8'h77);
    access(0, 0, 9'd5, 9'h1FF, 8'h00, q);
    chk("R4 precharge back", last_hi, T_RP);
    chk("R9 read after miss", q, 8'hC3);
  endtask

  task automatic t_timeout;
    logic [7:0] q;
    int rf;
    for (int i = 0; i < T_IDLE + T_CP + 10 && !ras_n; i++) @(negedge clk);
    #1;
    chk("R10 row closed", ras_n, 1);
    chk("R10 idle length", last_tail, T_CP + T_IDLE);
    repeat (4) @(negedge clk);
    chk("R10 row stays closed", ras_n, 1);
    rf = ras_falls;
    access(0, 1, 9'd5, 9'h00B, 8'h00, q);
    chk("R2 reopen from idle", ras_falls, rf + 1);
    chk("R2 ras-to-cas reopen", last_chi, T_RCD + 1);
    chk("R9 read after timeout", q, 8'h5A);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1-run watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 t_reset();
    t_closed_write();
    t_hit_writes();
    t_early_read();
    t_late_read();
    t_miss();
    t_timeout();
    repeat (3) @(negedge clk);
    chk("R5 cas only under ras", r5_err, 0);
    chk("R9 done aligned to cas rise", done_err, 0);
    summary();
  end
endmodule